// File: doc/BRIEF.md
# Multichannel PWM with Triggered Staged Updates

This block generates several independent pulse-width-modulated outputs from one input clock. Every channel owns a prescaler, a period count, a high-time count and a polarity setting. Software writes these into staging registers through a small word-addressed register port. Staged values do nothing to the pin until the channel's trigger bit goes from 0 to 1. That rising edge moves the staged set into the active set in one of two ways. In the immediate way, the new set is used after a fixed latency and the period restarts from zero. In the smooth way, the new set waits for the running period to finish.

The block has no enable bit. A high time of zero turns a channel off. While a channel's trigger bit and smooth bit are both 0, its pin is forced high. Each channel also drives an output enable. In push-pull mode the output enable is always asserted. In open-drain mode it is asserted only while the pin is low.

Top module: `shadow_pwm`

## Requirements
- R1: Synchronous active-low reset clears every register and the read data to 0. After reset every pin is 1 and every output enable is 0, because the output-type bits reset to open-drain.
- R2: Register map, with byte offsets on `addr_i`:
  - 0x00 is the control word. Channel c uses bit c as trigger, bit 8+c as polarity, bit 16+c as output type and bit 24+c as smooth.
  - 0x04 holds the prescale values, a 3-bit field for channel c at bit 4c.
  - Channel c's period count is at 0x08+8c and its high-time count is at 0x0C+8c. Both are 24 bits wide.
  - A read returns the last value written to that register, masked to its implemented bits. Unimplemented bits read as 0.
  - Read data appears on the clock edge that samples `rd_en_i`.
- R3: A read of any other offset returns 0. A write to any other offset changes no register and no output.
- R4: Writes to a channel's prescale, period, high time or polarity leave its output unchanged until that channel's trigger bit rises.
- R5: If the smooth bit is 0 when the trigger bit rises, the new settings drive the pin after the (LATENCY+1)-th clock edge that follows the write setting the trigger bit. The period and prescaler then restart from zero.
- R6: If the smooth bit is 1 when the trigger bit rises, the running waveform completes its current period. The new settings start on the clock edge that ends that period.
- R7: While a channel's trigger bit and smooth bit are both 0, its pin is 1. As soon as either bit is 1, the pin again follows the running waveform.
- R8: With period P ≥ 2, prescale S and high time H, each period lasts P·(S+1) clocks. The waveform is active for min(H,P)·(S+1) of those clocks, at the start of the period. The pin equals the active state when the polarity bit is 1 and its inverse when the polarity bit is 0. H = 0 gives a channel that is never active.
- R9: A period count of 0 or 1 keeps the channel permanently inactive.
- R10: Output type 1 (push-pull) keeps the output enable at 1. Output type 0 (open-drain) sets the output enable to 1 exactly when the pin is 0. The output type acts at once and is not staged.
- R11: Channels are independent. One control write may trigger several channels, and each one then runs from its own fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr_i | input | ADDR_W | Byte offset of the register accessed |
| wdata_i | input | 32 | Write data |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Read data, registered |
| pin_o | output | NUM_CH | Pin value per channel |
| oe_o | output | NUM_CH | Output enable per channel |

## Verification
The duty function is swept on one channel over:
- every period from 0 to 5;
- every high time from 0 to one above the period;
- prescale values 0, 2 and 7;
- both polarities and both output types.

Each run counts the active clocks over one full period. The count does not depend on where in the period the sample starts. It separates correct clipping of a high time above the period from an off-by-one compare, and prescale scaling from a plain counter. Directed sequences cover further cases:
- They pin down the exact edge of an immediate update.
- They check that a smooth update waits for a 40-count period to end rather than the latency.
- They check that staged writes without a trigger edge leave the pin alone.
- They check that the hold-high state is entered and left by the two control bits alone.

A final run triggers all channels with one write, each with different fields, to tell apart per-channel decoding and cross-channel wiring.

// File: rtl/spwm_pkg.sv
// Shared widths and the channel settings record for the triggered PWM.
// Assumes at most eight channels, since control bits are grouped in 8-bit lanes.
package spwm_pkg;
    localparam int DATA_W       = 32;
    localparam int CNT_W        = 24;
    localparam int PRE_W        = 3;
    localparam int LANE_W       = 8;
    localparam int FIELD_STRIDE = 4;

    // One complete set of waveform settings (staged or active).
    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [CNT_W-1:0] period;
        logic [CNT_W-1:0] high;
        logic             normal;   // 1: pin follows active state, 0: inverted
    } spwm_cfg_t;
endpackage

// File: rtl/spwm_regfile.sv
// Register file for the triggered PWM: control word, prescale word and per-channel
// period/high-time words. Holds staged values only; reads return what was written,
// masked to implemented bits. Unmapped offsets read zero and ignore writes.
// Assumes NUM_CH <= 8 and byte offsets on addr_i.
module spwm_regfile
    import spwm_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int ADDR_W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [ADDR_W-1:0]            addr_i,
    input  logic [DATA_W-1:0]            wdata_i,
    input  logic                         wr_en_i,
    input  logic                         rd_en_i,
    output logic [DATA_W-1:0]            rdata_o,
    output logic [NUM_CH-1:0]            trig_o,
    output logic [NUM_CH-1:0]            smooth_o,
    output logic [NUM_CH-1:0]            otype_o,
    output spwm_cfg_t [NUM_CH-1:0]       stage_o
);
    localparam int OFS_CTRL  = 0;
    localparam int OFS_PRE   = 4;
    localparam int OFS_CH0   = 8;
    localparam int CH_STRIDE = 8;
    localparam int HI_SKEW   = 4;
    localparam int LANE_TRIG = 0;
    localparam int LANE_POL  = 1;
    localparam int LANE_TYPE = 2;
    localparam int LANE_SMO  = 3;

    function automatic logic [DATA_W-1:0] ctrl_mask_f();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int lane = 0; lane < 4; lane++)
            for (int c = 0; c < NUM_CH; c++)
                m[lane*LANE_W + c] = 1'b1;
        return m;
    endfunction

    localparam logic [DATA_W-1:0] CTRL_MASK = ctrl_mask_f();

    logic [DATA_W-1:0] ctrl_q;
    logic [PRE_W-1:0]  pre_q [NUM_CH];
    logic [CNT_W-1:0]  per_q [NUM_CH];
    logic [CNT_W-1:0]  hi_q  [NUM_CH];
    logic              hit_ctrl, hit_pre, any_hit;
    logic [NUM_CH-1:0] hit_per, hit_hi;
    logic [DATA_W-1:0] rd_val;

    assign hit_ctrl = (addr_i == ADDR_W'(OFS_CTRL));
    assign hit_pre  = (addr_i == ADDR_W'(OFS_PRE));
    assign any_hit  = hit_ctrl | hit_pre | (|hit_per) | (|hit_hi);

    // Control word storage, unimplemented bits forced to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                    ctrl_q <= '0;
        else if (wr_en_i && hit_ctrl)  ctrl_q <= wdata_i & CTRL_MASK;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign hit_per[c] = (addr_i == ADDR_W'(OFS_CH0 + CH_STRIDE*c));
        assign hit_hi[c]  = (addr_i == ADDR_W'(OFS_CH0 + CH_STRIDE*c + HI_SKEW));

        // Per-channel staged prescale, period and high time.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pre_q[c] <= '0;
                per_q[c] <= '0;
                hi_q[c]  <= '0;
            end else if (wr_en_i) begin
                if (hit_pre)    pre_q[c] <= wdata_i[FIELD_STRIDE*c +: PRE_W];
                if (hit_per[c]) per_q[c] <= wdata_i[CNT_W-1:0];
                if (hit_hi[c])  hi_q[c]  <= wdata_i[CNT_W-1:0];
            end
        end

        assign trig_o[c]   = ctrl_q[LANE_TRIG*LANE_W + c];
        assign smooth_o[c] = ctrl_q[LANE_SMO*LANE_W + c];
        assign otype_o[c]  = ctrl_q[LANE_TYPE*LANE_W + c];
        assign stage_o[c]  = '{pre: pre_q[c], period: per_q[c], high: hi_q[c],
                               normal: ctrl_q[LANE_POL*LANE_W + c]};
    end

    // Read multiplexer over all mapped words.
    always_comb begin
        rd_val = '0;
        if (hit_ctrl) rd_val = ctrl_q;
        if (hit_pre)
            for (int c = 0; c < NUM_CH; c++)
                rd_val[FIELD_STRIDE*c +: PRE_W] = pre_q[c];
        for (int c = 0; c < NUM_CH; c++) begin
            if (hit_per[c]) rd_val = {{(DATA_W-CNT_W){1'b0}}, per_q[c]};
            if (hit_hi[c])  rd_val = {{(DATA_W-CNT_W){1'b0}}, hi_q[c]};
        end
    end

    // Registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n)        rdata_o <= '0;
        else if (rd_en_i)  rdata_o <= rd_val;
    end

    // R3: a read of an unmapped offset returns zero on the next cycle
    p_unmapped_read_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && !any_hit) |=> (rdata_o == '0));
endmodule

// File: rtl/spwm_shadow.sv
// Trigger edge detection and staged-to-active transfer for one channel.
// A 0->1 change of the trigger bit (against its previous-cycle value) captures the
// staged set as pending. Smooth mode applies it at the next wrap reported by the
// waveform generator; immediate mode applies it LATENCY cycles after detection.
// A newer trigger edge replaces a pending set. Assumes LATENCY >= 1.
module spwm_shadow
    import spwm_pkg::*;
#(
    parameter int LATENCY = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      trig_i,
    input  logic      smooth_i,
    input  spwm_cfg_t stage_i,
    input  logic      wrap_i,
    output spwm_cfg_t active_o,
    output logic      restart_o
);
    localparam int LAT_W = $clog2(LATENCY + 1);

    logic             trig_q, pend_q, pend_smooth_q, rise, apply;
    logic [LAT_W-1:0] lat_q;
    spwm_cfg_t        pend_cfg_q, act_q;

    assign rise      = trig_i & ~trig_q;
    assign apply     = pend_q && !rise && (pend_smooth_q ? wrap_i : (lat_q == LAT_W'(1)));
    assign active_o  = act_q;
    assign restart_o = apply;

    // Edge capture, pending set, latency countdown and active load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_q        <= 1'b0;
            pend_q        <= 1'b0;
            pend_smooth_q <= 1'b0;
            lat_q         <= '0;
            pend_cfg_q    <= '0;
            act_q         <= '0;
        end else begin
            trig_q <= trig_i;
            if (rise) begin
                pend_q        <= 1'b1;
                pend_smooth_q <= smooth_i;
                pend_cfg_q    <= stage_i;
                lat_q         <= LAT_W'(LATENCY);
            end else if (apply) begin
                pend_q <= 1'b0;
                act_q  <= pend_cfg_q;
            end else if (pend_q && !pend_smooth_q) begin
                lat_q <= lat_q - LAT_W'(1);
            end
        end
    end

    // R4: with nothing pending and no edge, the active set holds
    p_active_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_q && !rise) |=> $stable(act_q));
    // R6: a smooth update never lands off a period boundary
    p_smooth_on_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && pend_smooth_q && !wrap_i) |=> $stable(act_q));
    // R5: an immediate update does not land before its latency runs out
    p_latency_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !pend_smooth_q && lat_q != LAT_W'(1)) |=> $stable(act_q));
    // R5: countdown stays within its range while pending
    p_latency_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !pend_smooth_q) |-> (lat_q != '0 && lat_q <= LAT_W'(LATENCY)));
endmodule

// File: rtl/spwm_wave.sv
// Waveform generator for one channel: prescaler, period counter and pin/enable
// drive. Reports each period wrap. A restart pulse clears both counters.
// Assumes the active settings only change together with a restart pulse.
module spwm_wave
    import spwm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  spwm_cfg_t cfg_i,
    input  logic      restart_i,
    input  logic      hold_i,
    input  logic      otype_i,
    output logic      wrap_o,
    output logic      pin_o,
    output logic      oe_o
);
    logic [PRE_W-1:0] pre_cnt;
    logic [CNT_W-1:0] cnt;
    logic             tick, short_per, active, level;

    assign tick      = (pre_cnt >= cfg_i.pre);
    assign short_per = (cfg_i.period < CNT_W'(2));
    assign wrap_o    = tick && (short_per || (cnt >= cfg_i.period - CNT_W'(1)));
    assign active    = !short_per && (cnt < cfg_i.high);
    assign level     = cfg_i.normal ? active : !active;
    assign pin_o     = hold_i | level;
    assign oe_o      = otype_i | !pin_o;

    // Prescaler and period counter with wrap and restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i) begin
            pre_cnt <= '0;
            cnt     <= '0;
        end else begin
            pre_cnt <= tick ? '0 : pre_cnt + PRE_W'(1);
            if (wrap_o)    cnt <= '0;
            else if (tick) cnt <= cnt + CNT_W'(1);
        end
    end

    // R8: the period counter stays inside the programmed period
    p_count_in_period_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !short_per |-> (cnt < cfg_i.period));
    // R8: the prescaler never passes its programmed divide value
    p_prescale_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_cnt <= cfg_i.pre));
endmodule

// File: rtl/shadow_pwm.sv
// Top of the multichannel PWM with triggered staged updates. One register file
// feeds NUM_CH channels, each made of a shadow/transfer stage and a waveform
// generator. Pins are held high while a channel's trigger and smooth bits are 0.
// Assumes 1 <= NUM_CH <= 8 and ADDR_W large enough for offset 0x0C+8*(NUM_CH-1).
module shadow_pwm
    import spwm_pkg::*;
#(
    parameter int NUM_CH  = 6,
    parameter int ADDR_W  = 8,
    parameter int LATENCY = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [31:0]       wdata_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    output logic [31:0]       rdata_o,
    output logic [NUM_CH-1:0] pin_o,
    output logic [NUM_CH-1:0] oe_o
);
    logic [NUM_CH-1:0]     trig, smooth, otype;
    spwm_cfg_t [NUM_CH-1:0] stage;

    spwm_regfile #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_i   (addr_i),
        .wdata_i  (wdata_i),
        .wr_en_i  (wr_en_i),
        .rd_en_i  (rd_en_i),
        .rdata_o  (rdata_o),
        .trig_o   (trig),
        .smooth_o (smooth),
        .otype_o  (otype),
        .stage_o  (stage)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        spwm_cfg_t act;
        logic      restart, wrap, hold;

        assign hold = !trig[c] && !smooth[c];

        spwm_shadow #(.LATENCY(LATENCY)) u_shadow (
            .clk       (clk),
            .rst_n     (rst_n),
            .trig_i    (trig[c]),
            .smooth_i  (smooth[c]),
            .stage_i   (stage[c]),
            .wrap_i    (wrap),
            .active_o  (act),
            .restart_o (restart)
        );

        spwm_wave u_wave (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_i     (act),
            .restart_i (restart),
            .hold_i    (hold),
            .otype_i   (otype[c]),
            .wrap_o    (wrap),
            .pin_o     (pin_o[c]),
            .oe_o      (oe_o[c])
        );

        // R10: an open-drain channel never drives a high level
        p_od_no_drive_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
            !otype[c] |-> !(oe_o[c] && pin_o[c]));
    end
endmodule

// File: tb/tb_shadow_pwm.sv
module tb_shadow_pwm;
    localparam int NCH = 6;
    localparam int LAT = 4;
    localparam int AW  = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic          wr_en = 1'b0, rd_en = 1'b0;
    logic [31:0]   rdata;
    logic [NCH-1:0] pin, oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    shadow_pwm #(.NUM_CH(NCH), .ADDR_W(AW), .LATENCY(LAT)) dut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .wdata_i(wdata),
        .wr_en_i(wr_en), .rd_en_i(rd_en), .rdata_o(rdata), .pin_o(pin), .oe_o(oe)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        addr = AW'(a); wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        addr = AW'(a); rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    function automatic int per_a(input int c); return 8 + 8*c; endfunction
    function automatic int hi_a(input int c);  return 12 + 8*c; endfunction
    function automatic logic [31:0] ctrl_w(input logic [7:0] tr, input logic [7:0] po,
                                           input logic [7:0] ty, input logic [7:0] sm);
        return {sm, ty, po, tr};
    endfunction

    // Counts pin-high clocks of channel ch over w samples; flags open-drain/push-pull misuse.
    task automatic measure(input int ch, input int w, input bit ty,
                           output int highs, output int bad_oe);
        highs = 0; bad_oe = 0;
        for (int i = 0; i < w; i++) begin
            if (pin[ch]) highs++;
            if (ty ? (oe[ch] !== 1'b1) : (oe[ch] !== !pin[ch])) bad_oe++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] rv;
        int highs, bad, exp_act, w;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(pin == '1, "R1", "pins after reset", pin, 6'h3f);
        chk(oe == '0, "R1", "oe after reset", oe, 0);
        chk(rdata == '0, "R1", "rdata after reset", rdata, 0);
        rd(0, rv);          chk(rv == 0, "R1", "ctrl reset", rv, 0);
        rd(4, rv);          chk(rv == 0, "R1", "prescale reset", rv, 0);
        rd(per_a(5), rv);   chk(rv == 0, "R1", "period5 reset", rv, 0);

        // R2: register readback with masks
        wr(0, 32'hFFFF_FFFF); rd(0, rv);
        chk(rv == 32'h3F3F_3F3F, "R2", "ctrl mask", rv, 32'h3F3F_3F3F);
        wr(4, 32'hFFFF_FFFF); rd(4, rv);
        chk(rv == 32'h0077_7777, "R2", "prescale mask", rv, 32'h0077_7777);
        for (int c = 0; c < NCH; c++) begin
            wr(per_a(c), 32'hA500_0010 + 32'(c) * 32'h0011_1111);
            wr(hi_a(c),  32'h5A00_0020 + 32'(c) * 32'h0010_1010);
        end
        for (int c = 0; c < NCH; c++) begin
            rd(per_a(c), rv);
            chk(rv == (32'h0000_0010 + 32'(c) * 32'h0011_1111), "R2", "period readback",
                rv, 32'h0000_0010 + 32'(c) * 32'h0011_1111);
            rd(hi_a(c), rv);
            chk(rv == (32'h0000_0020 + 32'(c) * 32'h0010_1010), "R2", "high readback",
                rv, 32'h0000_0020 + 32'(c) * 32'h0010_1010);
        end
        wr(0, 32'h0);

        // R3: unmapped offsets
        foreach (rv[i]) begin end
        for (int k = 0; k < 5; k++) begin
            int a;
            a = (k == 0) ? 8'h02 : (k == 1) ? 8'h38 : (k == 2) ? 8'h3C : (k == 3) ? 8'h80 : 8'hFF;
            wr(a, 32'hFFFF_FFFF);
            rd(a, rv);
            chk(rv == 0, "R3", "unmapped read", rv, 0);
        end
        rd(0, rv); chk(rv == 0, "R3", "ctrl untouched by unmapped writes", rv, 0);
        rd(4, rv); chk(rv == 32'h0077_7777, "R3", "prescale untouched", rv, 32'h0077_7777);
        chk(pin == '1, "R3", "pins untouched by unmapped writes", pin, 6'h3f);

        // R5: exact immediate-update latency, inverted polarity, always-active config
        do_reset();
        wr(per_a(0), 10); wr(hi_a(0), 10);
        wr(0, ctrl_w(8'h01, 8'h00, 8'h01, 8'h00));
        repeat (LAT) @(negedge clk);
        chk(pin[0] == 1'b1, "R5", "pin before latency expires", pin[0], 1);
        @(negedge clk);
        chk(pin[0] == 1'b0, "R5", "pin after latency", pin[0], 0);

        // R4: staged high time without a trigger edge does nothing
        wr(hi_a(0), 0);
        bad = 0;
        for (int i = 0; i < 30; i++) begin
            if (pin[0] !== 1'b0) bad++;
            @(negedge clk);
        end
        chk(bad == 0, "R4", "pin changed without trigger edge", bad, 0);

        // R7: hold high with both bits low, waveform back with smooth set
        wr(0, ctrl_w(8'h00, 8'h00, 8'h01, 8'h00));
        chk(pin[0] == 1'b1, "R7", "held high", pin[0], 1);
        chk(oe[0] == 1'b1, "R7", "push-pull oe while held", oe[0], 1);
        wr(0, ctrl_w(8'h00, 8'h00, 8'h01, 8'h01));
        chk(pin[0] == 1'b0, "R7", "waveform resumes with smooth set", pin[0], 0);
        wr(0, ctrl_w(8'h01, 8'h00, 8'h01, 8'h00));
        repeat (LAT) @(negedge clk);
        chk(pin[0] == 1'b0, "R5", "second update before latency", pin[0], 0);
        @(negedge clk);
        chk(pin[0] == 1'b1, "R5", "second update applied (R4 staged value now used)", pin[0], 1);

        // R6: smooth update waits for the period boundary
        do_reset();
        wr(per_a(0), 40); wr(hi_a(0), 40);
        wr(0, ctrl_w(8'h01, 8'h01, 8'h01, 8'h00));
        repeat (LAT + 1) @(negedge clk);          // n = 0: period just restarted
        wr(per_a(0), 4);                          // n = 1
        wr(hi_a(0), 0);                           // n = 2
        wr(0, ctrl_w(8'h00, 8'h01, 8'h01, 8'h01));// n = 3
        wr(0, ctrl_w(8'h01, 8'h01, 8'h01, 8'h01));// n = 4
        repeat (35) @(negedge clk);               // n = 39
        chk(pin[0] == 1'b1, "R6", "old waveform until boundary", pin[0], 1);
        @(negedge clk);                           // n = 40
        chk(pin[0] == 1'b0, "R6", "new settings at boundary", pin[0], 0);

        // R8 R9 R10: sweep on channel 0
        do_reset();
        for (int p = 0; p <= 5; p++) begin
            for (int h = 0; h <= p + 1; h++) begin
                for (int si = 0; si < 3; si++) begin
                    for (int pol = 0; pol < 2; pol++) begin
                        int s;
                        bit ty;
                        s  = (si == 0) ? 0 : (si == 1) ? 2 : 7;
                        ty = (si + pol) % 2 == 1;
                        wr(0, ctrl_w(8'h00, 8'h00, {7'b0, ty}, 8'h00));
                        wr(4, 32'(s));
                        wr(per_a(0), 32'(p));
                        wr(hi_a(0), 32'(h));
                        wr(0, ctrl_w(8'h01, {7'b0, pol[0]}, {7'b0, ty}, 8'h00));
                        repeat (LAT + 2) @(negedge clk);
                        w = ((p >= 2) ? p : 4) * (s + 1);
                        exp_act = (p >= 2) ? (((h < p) ? h : p) * (s + 1)) : 0;
                        if (pol == 0) exp_act = w - exp_act;
                        measure(0, w, ty, highs, bad);
                        if (p < 2) chk(highs == exp_act, "R9", "short period level", highs, exp_act);
                        else       chk(highs == exp_act, "R8", "high clocks per period", highs, exp_act);
                        chk(bad == 0, "R10", "oe rule violations", bad, 0);
                    end
                end
            end
        end

        // R11: all channels triggered by one write, each with its own fields
        do_reset();
        rv = '0;
        for (int c = 0; c < NCH; c++) rv[4*c +: 3] = 3'((c + 1) % 8);
        wr(4, rv);
        for (int c = 0; c < NCH; c++) begin
            wr(per_a(c), 32'(2 + c));
            wr(hi_a(c), 32'(c % 3 + 1));
        end
        wr(0, ctrl_w(8'h3F, 8'h15, 8'h3F, 8'h00));
        repeat (LAT + 2) @(negedge clk);
        for (int c = 0; c < NCH; c++) begin
            int pp, hh, ss;
            pp = 2 + c; hh = c % 3 + 1; ss = (c + 1) % 8;
            w = pp * (ss + 1);
            exp_act = ((hh < pp) ? hh : pp) * (ss + 1);
            if (c % 2 == 1) exp_act = w - exp_act;
            measure(c, w, 1'b1, highs, bad);
            chk(highs == exp_act, "R11", $sformatf("channel %0d high clocks", c), highs, exp_act);
            chk(bad == 0, "R11", "push-pull oe on all channels", bad, 0);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule